// File: doc/BRIEF.md
# One-Wire ROM Search Engine

This block walks the whole device tree of a single-wire bus on its own and reports every device identifier it finds, with no help from a processor. It sits above a bus master that carries out three kinds of request: a bus reset with presence detection, a byte write, and a single time slot. A time slot written with 1 also samples the line. Each request is a one-cycle pulse. The master answers with a one-cycle acknowledge, which may come no earlier than the cycle after the request.

A search runs as a series of passes. Each pass resets the bus and sends the search command. It then resolves one identifier bit per position, least significant first. At each position it reads the true bit and its complement, then writes back the direction it takes. The engine keeps the branch point from the previous pass, the highest position where a conflict was resolved toward 0, and the previous identifier. From these it decides where the next pass turns toward 1. Each complete pass yields one identifier on a one-cycle strobe. The search ends with a done pulse and a two-bit status.

A second, smaller sequence addresses one device: a bus reset, the match command, then the identifier bytes.

Top module: `owire_enum`

## Requirements
- R1: While reset is held and after it is released, the engine is idle: `busy`, `done`, `found_valid` and all three request outputs are 0.
- R2: Every search pass begins with a bus reset request. If the acknowledge reports no presence, the search ends with `done` and status 2'b01 (none), and that pass reports no identifier.
- R3: After a presence, a pass writes the byte 0xF0. It then runs ID_BITS triplets, each made of two time slots with `bus_slot_wbit`=1 (true bit, then complement) followed by one time slot that writes the chosen direction.
- R4: If the two bits read differ, the direction is the true bit. If both read 0, the direction is the requested one: 1 at the stored branch point, 0 above it, and the previous pass's identifier bit below it. The direction at position i becomes bit i of the identifier.
- R5: If both bits read 1, the pass is abandoned at once. It reports no identifier, and the search ends with status 2'b10 (aborted).
- R6: Each completed pass raises `found_valid` for exactly one cycle with the full identifier. With a stable population, every device is reported exactly once, in ascending order of its bit-reversed identifier.
- R7: After a completed pass, the search ends with status 2'b00 (ok) if no conflict was resolved toward 0, or if the last such position equals the stored branch point. Otherwise that position becomes the new branch point and another pass starts.
- R8: A start pulse (`srch_start` or `sel_start`) while `busy` is 1 has no effect. `done` is a single-cycle pulse, given in the cycle in which `busy` has already returned to 0.
- R9: Every new search starts with the branch point at ID_BITS (none), the last-zero position unset and the previous identifier cleared, whatever an earlier search left behind.
- R10: A select sequence sends a bus reset, then the byte 0x55, then the ID_BITS/8 bytes of `sel_id`, lowest byte first, and ends with status ok. With no presence it sends no byte and ends with status none.
- R11: At most one request is outstanding at a time. Each request output is high for one cycle only, and none is raised while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| srch_start | input | 1 | Pulse: begin a full tree search |
| sel_start | input | 1 | Pulse: begin the select sequence for `sel_id` |
| sel_id | input | ID_BITS | Identifier to address, sampled at `sel_start` |
| busy | output | 1 | A search or select is in progress |
| bus_rst_req | output | 1 | Request a bus reset with presence detection |
| bus_byte_req | output | 1 | Request a byte write |
| bus_byte | output | 8 | Byte to write, valid with `bus_byte_req` |
| bus_slot_req | output | 1 | Request one time slot |
| bus_slot_wbit | output | 1 | Bit written in the slot (1 also samples the line) |
| bus_ack | input | 1 | One-cycle completion of the outstanding request |
| bus_present | input | 1 | Presence seen, valid with `bus_ack` after a reset |
| bus_rbit | input | 1 | Sampled line value, valid with `bus_ack` after a slot |
| found_valid | output | 1 | One-cycle strobe: `found_id` holds a new identifier |
| found_id | output | ID_BITS | Identifier from the last completed pass |
| done | output | 1 | One-cycle pulse: search or select finished |
| done_status | output | 2 | 00 ok, 01 none present, 10 aborted; held after `done` |

## Verification
The bench builds the engine with ID_BITS=16. Passes are therefore short enough that many tree shapes fit in the run: single devices, conflicts at bit 0 and at bit 15, and complementary identifiers that conflict at every position. The select sequence still spans two identifier bytes, so the lowest-byte-first order can be observed. A wired-AND device model can make all devices fall silent at a chosen pass and bit. This reaches the abort path both on the first pass and after an identifier has already been reported. A rerun after an abort shows that the branch state is cleared at each start.

// File: rtl/owe_pkg.sv
`timescale 1ns/1ps
package owe_pkg;

    localparam logic [7:0] CMD_SEARCH = 8'hF0;
    localparam logic [7:0] CMD_MATCH  = 8'h55;

    typedef enum logic [1:0] {
        ST_OK    = 2'b00,
        ST_NONE  = 2'b01,
        ST_ABORT = 2'b10
    } status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST,
        S_CMD,
        S_RDID,
        S_RDCP,
        S_WR,
        S_PASS,
        S_SRST,
        S_SCMD,
        S_SBYTE
    } state_e;

    typedef enum logic [1:0] {
        BK_SEARCH,
        BK_MATCH,
        BK_IDBYTE
    } byte_kind_e;

    // Triplet result: direction taken, complement bit, true bit.
    typedef struct packed {
        logic dir;
        logic cmp;
        logic idb;
    } trip_t;

    function automatic trip_t trip_decide(input logic idb, input logic cmpb,
                                          input logic req);
        trip_t t;
        t.idb = idb;
        t.cmp = cmpb;
        if (idb ^ cmpb)
            t.dir = idb;
        else if (idb & cmpb)
            t.dir = 1'b0;
        else
            t.dir = req;
        return t;
    endfunction

endpackage

// File: rtl/owe_dir_sel.sv
`timescale 1ns/1ps
module owe_dir_sel #(
    parameter int ID_BITS = 64,
    parameter int IDX_W   = $clog2(ID_BITS + 1)
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [IDX_W-1:0]   branch_pt,
    input  logic [ID_BITS-1:0] prev_id,
    output logic               req_dir
);
    logic [ID_BITS-1:0] prev_sh;

    always_comb begin
        prev_sh = prev_id >> idx;
        if (idx == branch_pt)
            req_dir = 1'b1;
        else if (idx > branch_pt)
            req_dir = 1'b0;
        else
            req_dir = prev_sh[0];
    end
endmodule

// File: rtl/owe_trk.sv
`timescale 1ns/1ps
module owe_trk
    import owe_pkg::*;
#(
    parameter int ID_BITS = 64,
    parameter int IDX_W   = $clog2(ID_BITS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init,
    input  logic               pass_begin,
    input  logic               step,
    input  logic               advance,
    input  logic [IDX_W-1:0]   idx,
    input  logic               idb,
    input  logic               cmpb,
    output logic               wbit,
    output logic [ID_BITS-1:0] acc,
    output logic               end_now
);
    localparam logic [IDX_W-1:0] NO_BRANCH = IDX_W'(ID_BITS);

    logic [IDX_W-1:0]   branch_pt;
    logic [IDX_W-1:0]   last_zero;
    logic               lz_set;
    logic [ID_BITS-1:0] prev_id;
    logic [ID_BITS-1:0] acc_nxt;
    logic               req_dir;
    trip_t              trip;

    owe_dir_sel #(.ID_BITS(ID_BITS), .IDX_W(IDX_W)) u_dir (
        .idx       (idx),
        .branch_pt (branch_pt),
        .prev_id   (prev_id),
        .req_dir   (req_dir)
    );

    assign trip = trip_decide(idb, cmpb, req_dir);
    assign wbit = trip.dir;

    for (genvar g = 0; g < ID_BITS; g++) begin : g_acc
        assign acc_nxt[g] = (step && idx == IDX_W'(g)) ? trip.dir : acc[g];
    end

    assign end_now = !lz_set || (last_zero == branch_pt);

    always_ff @(posedge clk) begin
        if (rst || init) begin
            branch_pt <= NO_BRANCH;
            last_zero <= '0;
            lz_set    <= 1'b0;
            prev_id   <= '0;
            acc       <= '0;
        end else begin
            if (pass_begin)
                acc <= '0;
            else
                acc <= acc_nxt;
            if (step && trip == 3'b000) begin
                last_zero <= idx;
                lz_set    <= 1'b1;
            end
            if (advance) begin
                branch_pt <= last_zero;
                prev_id   <= acc;
            end
        end
    end
endmodule

// File: rtl/owe_byte_sel.sv
`timescale 1ns/1ps
module owe_byte_sel
    import owe_pkg::*;
#(
    parameter int ID_BITS = 64,
    parameter int NBYTES  = ID_BITS / 8,
    parameter int BC_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  byte_kind_e         kind,
    input  logic [BC_W-1:0]    bcnt,
    input  logic [ID_BITS-1:0] id,
    output logic [7:0]         data
);
    logic [7:0] id_bytes [NBYTES];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign id_bytes[b] = id[8*b +: 8];
    end

    always_comb begin
        data = 8'h00;
        case (kind)
            BK_SEARCH: data = CMD_SEARCH;
            BK_MATCH:  data = CMD_MATCH;
            BK_IDBYTE: begin
                for (int b = 0; b < NBYTES; b++)
                    if (bcnt == BC_W'(b))
                        data = id_bytes[b];
            end
            default:   data = 8'h00;
        endcase
    end
endmodule

// File: rtl/owire_enum.sv
`timescale 1ns/1ps
module owire_enum
    import owe_pkg::*;
#(
    parameter int ID_BITS = 64
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               srch_start,
    input  logic               sel_start,
    input  logic [ID_BITS-1:0] sel_id,
    output logic               busy,
    output logic               bus_rst_req,
    output logic               bus_byte_req,
    output logic [7:0]         bus_byte,
    output logic               bus_slot_req,
    output logic               bus_slot_wbit,
    input  logic               bus_ack,
    input  logic               bus_present,
    input  logic               bus_rbit,
    output logic               found_valid,
    output logic [ID_BITS-1:0] found_id,
    output logic               done,
    output logic [1:0]         done_status
);
    localparam int IDX_W  = $clog2(ID_BITS + 1);
    localparam int NBYTES = ID_BITS / 8;
    localparam int BC_W   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ID_BITS - 1);
    localparam logic [BC_W-1:0]  LAST_BYTE = BC_W'(NBYTES - 1);

    state_e             state;
    logic               pend;
    logic               ack_ok;
    logic [IDX_W-1:0]   idx;
    logic [BC_W-1:0]    bcnt;
    logic               idb_q;
    logic               cmp_q;
    logic [ID_BITS-1:0] sel_q;
    logic               any_req;
    logic               trk_wbit;
    logic [ID_BITS-1:0] trk_acc;
    logic               trk_end;
    logic               trk_init;
    logic               trk_begin;
    logic               trk_step;
    logic               trk_adv;
    byte_kind_e         bkind;

    assign busy    = (state != S_IDLE);
    assign ack_ok  = pend && bus_ack;

    assign bus_rst_req  = (state == S_RST || state == S_SRST) && !pend;
    assign bus_byte_req = (state == S_CMD || state == S_SCMD || state == S_SBYTE) && !pend;
    assign bus_slot_req = (state == S_RDID || state == S_RDCP || state == S_WR) && !pend;
    assign bus_slot_wbit = (state == S_WR) ? trk_wbit : 1'b1;
    assign any_req = bus_rst_req || bus_byte_req || bus_slot_req;

    always_comb begin
        case (state)
            S_SCMD:  bkind = BK_MATCH;
            S_SBYTE: bkind = BK_IDBYTE;
            default: bkind = BK_SEARCH;
        endcase
    end

    assign trk_init  = (state == S_IDLE) && srch_start;
    assign trk_begin = (state == S_RST) && ack_ok && bus_present;
    assign trk_step  = (state == S_WR) && ack_ok;
    assign trk_adv   = (state == S_PASS) && !trk_end;

    owe_trk #(.ID_BITS(ID_BITS), .IDX_W(IDX_W)) u_trk (
        .clk        (clk),
        .rst        (rst),
        .init       (trk_init),
        .pass_begin (trk_begin),
        .step       (trk_step),
        .advance    (trk_adv),
        .idx        (idx),
        .idb        (idb_q),
        .cmpb       (cmp_q),
        .wbit       (trk_wbit),
        .acc        (trk_acc),
        .end_now    (trk_end)
    );

    owe_byte_sel #(.ID_BITS(ID_BITS), .NBYTES(NBYTES), .BC_W(BC_W)) u_bsel (
        .kind (bkind),
        .bcnt (bcnt),
        .id   (sel_q),
        .data (bus_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= S_IDLE;
            pend        <= 1'b0;
            idx         <= '0;
            bcnt        <= '0;
            idb_q       <= 1'b0;
            cmp_q       <= 1'b0;
            sel_q       <= '0;
            found_valid <= 1'b0;
            found_id    <= '0;
            done        <= 1'b0;
            done_status <= ST_OK;
        end else begin
            found_valid <= 1'b0;
            done        <= 1'b0;
            if (any_req)
                pend <= 1'b1;
            else if (ack_ok)
                pend <= 1'b0;

            case (state)
                S_IDLE: begin
                    if (srch_start) begin
                        state <= S_RST;
                    end else if (sel_start) begin
                        sel_q <= sel_id;
                        state <= S_SRST;
                    end
                end
                S_RST: if (ack_ok) begin
                    if (bus_present) begin
                        state <= S_CMD;
                    end else begin
                        done        <= 1'b1;
                        done_status <= ST_NONE;
                        state       <= S_IDLE;
                    end
                end
                S_CMD: if (ack_ok) begin
                    idx   <= '0;
                    state <= S_RDID;
                end
                S_RDID: if (ack_ok) begin
                    idb_q <= bus_rbit;
                    state <= S_RDCP;
                end
                S_RDCP: if (ack_ok) begin
                    cmp_q <= bus_rbit;
                    if (idb_q && bus_rbit) begin
                        done        <= 1'b1;
                        done_status <= ST_ABORT;
                        state       <= S_IDLE;
                    end else begin
                        state <= S_WR;
                    end
                end
                S_WR: if (ack_ok) begin
                    if (idx == LAST_IDX) begin
                        state <= S_PASS;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_RDID;
                    end
                end
                S_PASS: begin
                    found_valid <= 1'b1;
                    found_id    <= trk_acc;
                    if (trk_end) begin
                        done        <= 1'b1;
                        done_status <= ST_OK;
                        state       <= S_IDLE;
                    end else begin
                        state <= S_RST;
                    end
                end
                S_SRST: if (ack_ok) begin
                    if (bus_present) begin
                        state <= S_SCMD;
                    end else begin
                        done        <= 1'b1;
                        done_status <= ST_NONE;
                        state       <= S_IDLE;
                    end
                end
                S_SCMD: if (ack_ok) begin
                    bcnt  <= '0;
                    state <= S_SBYTE;
                end
                S_SBYTE: if (ack_ok) begin
                    if (bcnt == LAST_BYTE) begin
                        done        <= 1'b1;
                        done_status <= ST_OK;
                        state       <= S_IDLE;
                    end else begin
                        bcnt <= bcnt + 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/owe_chk.sv
`timescale 1ns/1ps
module owe_chk (
    input logic       clk,
    input logic       rst,
    input logic       srch_start,
    input logic       sel_start,
    input logic       busy,
    input logic       bus_rst_req,
    input logic       bus_byte_req,
    input logic       bus_slot_req,
    input logic       found_valid,
    input logic       done,
    input logic [1:0] done_status
);
    logic any_req;
    assign any_req = bus_rst_req || bus_byte_req || bus_slot_req;

    // R11
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({bus_rst_req, bus_byte_req, bus_slot_req}));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !any_req);

    // R11
    req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        any_req |=> !any_req);

    // R6
    found_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        found_valid |=> !found_valid);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && done_status != 2'b11));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(srch_start || sel_start));
endmodule

bind owire_enum owe_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .srch_start   (srch_start),
    .sel_start    (sel_start),
    .busy         (busy),
    .bus_rst_req  (bus_rst_req),
    .bus_byte_req (bus_byte_req),
    .bus_slot_req (bus_slot_req),
    .found_valid  (found_valid),
    .done         (done),
    .done_status  (done_status)
);

// File: tb/sim_owire_enum.sv
`timescale 1ns/1ps
module sim_owire_enum;
    localparam int IDB = 16;
    localparam int NB  = IDB / 8;
    localparam int NROW = 8;

    // row: [73:71] devices, [70:68] drop pass (0 none), [67:64] drop bit, [63:0] id3..id0
    localparam logic [73:0] VEC [NROW] = '{
        {3'd0, 3'd0, 4'd0, 64'h0},
        {3'd1, 3'd0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h1234},
        {3'd2, 3'd0, 4'd0, 16'h0, 16'h0, 16'h0001, 16'h0000},
        {3'd3, 3'd0, 4'd0, 16'h0, 16'h25C3, 16'hA5C2, 16'hA5C3},
        {3'd4, 3'd0, 4'd0, 16'h7FFF, 16'h8000, 16'h0000, 16'hFFFF},
        {3'd2, 3'd1, 4'd5, 16'h0, 16'h0, 16'h00F0, 16'h0F0F},
        {3'd3, 3'd2, 4'd9, 16'h0, 16'h1111, 16'h2222, 16'h4444},
        {3'd2, 3'd0, 4'd0, 16'h0, 16'h0, 16'h8001, 16'h0001}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic srch_start = 1'b0;
    logic sel_start = 1'b0;
    logic [IDB-1:0] sel_id = '0;
    logic busy, bus_rst_req, bus_byte_req, bus_slot_req, bus_slot_wbit;
    logic [7:0] bus_byte;
    logic bus_ack = 1'b0;
    logic bus_present = 1'b0;
    logic bus_rbit = 1'b1;
    logic found_valid, done;
    logic [IDB-1:0] found_id;
    logic [1:0] done_status;

    always #2.5 clk = ~clk;

    owire_enum #(.ID_BITS(IDB)) u0 (
        .clk(clk), .rst(rst), .srch_start(srch_start), .sel_start(sel_start),
        .sel_id(sel_id), .busy(busy), .bus_rst_req(bus_rst_req),
        .bus_byte_req(bus_byte_req), .bus_byte(bus_byte),
        .bus_slot_req(bus_slot_req), .bus_slot_wbit(bus_slot_wbit),
        .bus_ack(bus_ack), .bus_present(bus_present), .bus_rbit(bus_rbit),
        .found_valid(found_valid), .found_id(found_id), .done(done),
        .done_status(done_status)
    );

    // device model (wired-AND bus)
    logic [IDB-1:0] dev [4];
    logic act [4];
    int dev_n = 0, drop_pass = 0, drop_bit = 0;
    int bitpos = 0, phase = 0, pass_no = 0, nrst = 0, nblog = 0, proto_err = 0;
    logic [7:0] blog [16];
    logic dly = 1'b0, r_pres = 1'b0, r_bit = 1'b1;

    // monitor
    logic [IDB-1:0] got [8];
    int ng = 0, ndone = 0;
    logic [1:0] last_st = 2'b11;

    int nchk = 0, nfail = 0;

    always @(negedge clk) begin
        bus_ack <= 1'b0;
        if (dly) begin
            bus_ack     <= 1'b1;
            bus_present <= r_pres;
            bus_rbit    <= r_bit;
            dly = 1'b0;
        end
        if (!rst && bus_rst_req) begin
            for (int k = 0; k < 4; k++) act[k] = (k < dev_n);
            bitpos = 0; phase = 0; pass_no++; nrst++;
            r_pres = (dev_n > 0); r_bit = 1'b1; dly = 1'b1;
        end else if (!rst && bus_byte_req) begin
            if (nblog < 16) blog[nblog] = bus_byte;
            nblog++;
            dly = 1'b1;
        end else if (!rst && bus_slot_req) begin
            if (phase == 0 && pass_no == drop_pass && bitpos == drop_bit)
                for (int k = 0; k < 4; k++) act[k] = 1'b0;
            r_bit = 1'b1;
            if (phase == 0) begin
                if (!bus_slot_wbit) proto_err++;
                for (int k = 0; k < 4; k++) if (act[k]) r_bit &= dev[k][bitpos];
            end else if (phase == 1) begin
                if (!bus_slot_wbit) proto_err++;
                for (int k = 0; k < 4; k++) if (act[k]) r_bit &= ~dev[k][bitpos];
            end else begin
                for (int k = 0; k < 4; k++)
                    if (act[k] && dev[k][bitpos] != bus_slot_wbit) act[k] = 1'b0;
                bitpos++;
            end
            phase = (phase + 1) % 3;
            dly = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (!rst && found_valid) begin
            if (ng < 8) got[ng] = found_id;
            ng++;
        end
        if (!rst && done) begin
            ndone++;
            last_st = done_status;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] a,
                       input logic [63:0] e);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
        end
    endtask

    task automatic clear_logs();
        ng = 0; ndone = 0; nrst = 0; nblog = 0; pass_no = 0; proto_err = 0;
        last_st = 2'b11;
    endtask

    task automatic wait_done(input bit poke);
        int cyc = 0;
        while (ndone == 0 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 40) begin srch_start = 1'b1; sel_start = 1'b1; end
            if (poke && cyc == 41) begin srch_start = 1'b0; sel_start = 1'b0; end
        end
        chk(ndone != 0, "R8 done within bound", ndone, 1);
        repeat (6) @(negedge clk);
    endtask

    task automatic load_row(input logic [73:0] row);
        dev_n = int'(row[73:71]);
        drop_pass = int'(row[70:68]);
        drop_bit = int'(row[67:64]);
        for (int k = 0; k < 4; k++) dev[k] = row[16*k +: 16];
    endtask

    task automatic run_search(input bit poke);
        clear_logs();
        @(negedge clk); srch_start = 1'b1;
        @(negedge clk); srch_start = 1'b0;
        wait_done(poke);
    endtask

    // expected order: ascending bit-reversed identifier
    task automatic expect_list(output logic [IDB-1:0] ex [4]);
        logic [IDB-1:0] tmp [4];
        logic used [4];
        for (int k = 0; k < 4; k++) begin tmp[k] = dev[k]; used[k] = 1'b0; ex[k] = '0; end
        for (int s = 0; s < dev_n; s++) begin
            int best = -1;
            for (int k = 0; k < dev_n; k++)
                if (!used[k] && (best < 0 || {<<{tmp[k]}} < {<<{tmp[best]}})) best = k;
            used[best] = 1'b1;
            ex[s] = tmp[best];
        end
    endtask

    task automatic check_search(input string tag);
        logic [IDB-1:0] ex [4];
        int ecnt, erst;
        logic [1:0] est;
        expect_list(ex);
        if (dev_n == 0) begin est = 2'b01; ecnt = 0; erst = 1; end
        else if (drop_pass != 0) begin est = 2'b10; ecnt = drop_pass - 1; erst = drop_pass; end
        else begin est = 2'b00; ecnt = dev_n; erst = dev_n; end
        chk(last_st == est, {tag, " R2/R5/R7 status"}, last_st, est);
        chk(ng == ecnt, {tag, " R6 id count"}, ng, ecnt);
        for (int s = 0; s < ecnt && s < ng; s++)
            chk(got[s] == ex[s], {tag, " R4 R6 id order"}, got[s], ex[s]);
        chk(ndone == 1, {tag, " R8 single done"}, ndone, 1);
        chk(nrst == erst, {tag, " R2 reset per pass"}, nrst, erst);
        chk(nblog == ((dev_n == 0) ? 0 : erst), {tag, " R3 command count"}, nblog, erst);
        for (int b = 0; b < nblog && b < 16; b++)
            chk(blog[b] == 8'hF0, {tag, " R3 search byte"}, blog[b], 8'hF0);
        chk(proto_err == 0, {tag, " R3 read slots write 1"}, proto_err, 0);
    endtask

    initial begin
        #1000000;
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", nchk, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while reset is held
        chk(!busy && !done && !found_valid, "R1 in reset", {busy, done, found_valid}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !found_valid && !bus_rst_req && !bus_byte_req && !bus_slot_req,
            "R1 after reset", {busy, done, found_valid, bus_rst_req, bus_byte_req, bus_slot_req}, 0);

        for (int r = 0; r < NROW; r++) begin
            load_row(VEC[r]);
            run_search(1'b0);
            check_search($sformatf("row%0d", r));
        end

        // R9: rerun after an abort gives the full list again
        load_row(VEC[6]);
        run_search(1'b0);
        load_row(VEC[4]);
        run_search(1'b0);
        check_search("R9 rerun after abort");

        // R8: start pulses while busy are ignored
        load_row(VEC[4]);
        run_search(1'b1);
        check_search("R8 start while busy");
        chk(nrst == 4 && nblog == 4, "R8 no extra sequence", nrst, 4);

        // R10: select sequence
        dev_n = 1; dev[0] = 16'hBEEF; drop_pass = 0;
        clear_logs();
        sel_id = 16'hBEEF;
        @(negedge clk); sel_start = 1'b1;
        @(negedge clk); sel_start = 1'b0; sel_id = 16'h0000;
        wait_done(1'b0);
        chk(last_st == 2'b00, "R10 select status", last_st, 0);
        chk(nrst == 1, "R10 select reset", nrst, 1);
        chk(nblog == 1 + NB, "R10 select byte count", nblog, 1 + NB);
        chk(blog[0] == 8'h55, "R10 match byte", blog[0], 8'h55);
        chk(blog[1] == 8'hEF, "R10 low byte first", blog[1], 8'hEF);
        chk(blog[2] == 8'hBE, "R10 high byte last", blog[2], 8'hBE);
        chk(ng == 0, "R10 no identifier", ng, 0);

        dev_n = 0;
        clear_logs();
        @(negedge clk); sel_start = 1'b1;
        @(negedge clk); sel_start = 1'b0;
        wait_done(1'b0);
        chk(last_st == 2'b01, "R10 select none", last_st, 1);
        chk(nblog == 0, "R10 no byte without presence", nblog, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule